// File: doc/BRIEF.md
# Disk Drive Control Latch and Select Router

This block sits on a small processor bus and turns accesses inside a 2 KiB control window into drive control levels for a floppy disk interface. Each qualified bus cycle is decoded by address and direction. Reads and writes to the same 32-byte span do different things. Reads move a head-select level. Writes move an active-low drive-type select. Three exact write locations control the rest: two set a routing latch, and the third sends a short reset pulse to the disk controller.

The routing latch steers one incoming active-low drive-2 enable. It goes either to the external disk port enable or to the internal drive enable. The output that is not chosen is held high, which is its inactive level.

A bus cycle is qualified when the window select is low and the bus phase is high, sampled on the rising edge of `clk`. Holding a qualified cycle over several clocks repeats the same action. That is harmless for every latch, but it stretches the controller reset pulse.

Top module: `dsk_ctl_router`

## Requirements
- R1: While `rst_n` is low on a clock edge, and after its release until the first qualified access, `head_sel`=0, `dtype_sel_n`=1 and `ctlr_rst`=0, and the drive-2 enable is routed to `ext_en_n`. Bus activity during reset is ignored.
- R2: A qualified read (`bus_rd`=1) at any address from 0xCE40 to 0xCE5F clears `head_sel` to 0 on the next clock.
- R3: A qualified read at any address from 0xCE60 to 0xCE7F sets `head_sel` to 1 on the next clock.
- R4: A qualified write (`bus_rd`=0) at any address from 0xCE40 to 0xCE5F drives `dtype_sel_n` low on the next clock.
- R5: A qualified write at any address from 0xCE60 to 0xCE7F drives `dtype_sel_n` high on the next clock.
- R6: A qualified write to exactly 0xCC80 routes `drv2_en_n` to `int_en_n` from the next clock on.
- R7: A qualified write to exactly 0xCCC0 routes `drv2_en_n` to `ext_en_n` from the next clock on.
- R8: The routed output follows `drv2_en_n` in the same cycle. The other output stays at 1.
- R9: For each clock holding a qualified write to exactly 0xCC40, `ctlr_rst` is 1 during the next clock. Otherwise it is 0.
- R10: Without a qualified cycle (`win_sel_n`=1 or `bus_phi`=0), no latched output changes, whatever the address.
- R11: Qualified accesses that hit no decoded location change nothing. This covers addresses outside 0xC800–0xCFFF, other offsets in the window, and reads of 0xCC40, 0xCC80 and 0xCCC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all latches update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_phi | input | 1 | Bus clock phase; an access counts only while high |
| win_sel_n | input | 1 | Active-low select of the control window |
| drv2_en_n | input | 1 | Active-low drive-2 enable from the disk controller |
| head_sel | output | 1 | Head-select level |
| dtype_sel_n | output | 1 | Active-low drive-type select |
| ctlr_rst | output | 1 | Active-high reset pulse to the disk controller |
| ext_en_n | output | 1 | Active-low external port drive enable |
| int_en_n | output | 1 | Active-low internal drive enable |

## Verification
A wrong head-select or drive-type latch shows on its own pin one clock after the access that went wrong, and it stays wrong until the next access to the opposite span. A wrong routing bit shows in the same cycle as the fault, but only while `drv2_en_n` is low. For that reason the bench toggles the drive-2 enable under both routings. Decode faults at span edges or on the wrong direction show one clock after the access. The bench probes the first and last byte of each span, the byte just outside it, and each exact location read instead of written.

// File: rtl/dsk_ctl_pkg.sv
// Shared types for the disk control latch block.
// Assumes addresses are compared as 32-bit unsigned values.
package dsk_ctl_pkg;

    // One decoded action per qualified bus cycle; several may not be set at once.
    typedef struct packed {
        logic hd_clr;
        logic hd_set;
        logic dt_assert;
        logic dt_deassert;
        logic route_int;
        logic route_ext;
        logic ctlr_pulse;
    } dsk_cmd_t;

    // True when addr lies in [lo, lo+len).
    function automatic logic in_span(input logic [31:0] addr,
                                     input logic [31:0] lo,
                                     input logic [31:0] len);
        return (addr >= lo) && (addr < lo + len);
    endfunction

endpackage

// File: rtl/dsk_ctl_decode.sv
// Address/direction decoder.
// Turns one bus cycle into a set of action strobes. An access is
// qualified only with the window select low, the bus phase high and the
// address inside the control window. Assumes the spans do not overlap
// the exact locations.
module dsk_ctl_decode
    import dsk_ctl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [31:0] WIN_BASE  = 32'h0000_C800,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_0800,
    parameter logic [31:0] SPAN_LO   = 32'h0000_CE40,
    parameter logic [31:0] SPAN_HI   = 32'h0000_CE60,
    parameter logic [31:0] SPAN_LEN  = 32'h0000_0020,
    parameter logic [31:0] RT_INT_A  = 32'h0000_CC80,
    parameter logic [31:0] RT_EXT_A  = 32'h0000_CCC0,
    parameter logic [31:0] CRST_A    = 32'h0000_CC40
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_phi,
    input  logic              win_sel_n,
    output dsk_cmd_t          cmd
);
    localparam int NSPAN = 2;
    localparam logic [31:0] SPAN_BASE [NSPAN] = '{SPAN_LO, SPAN_HI};

    logic [31:0]      a32;
    logic             in_win;
    logic             qual;
    logic [NSPAN-1:0] span_hit;

    // Widen the address for comparisons.
    assign a32    = 32'(bus_addr);
    assign in_win = in_span(a32, WIN_BASE, WIN_SIZE);
    assign qual   = !win_sel_n && bus_phi && in_win;

    // One comparator per read/write span.
    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        assign span_hit[g] = in_span(a32, SPAN_BASE[g], SPAN_LEN);
    end

    // Combine qualification, direction and location into action strobes.
    always_comb begin
        cmd             = '0;
        cmd.hd_clr      = qual &&  bus_rd && span_hit[0];
        cmd.hd_set      = qual &&  bus_rd && span_hit[1];
        cmd.dt_assert   = qual && !bus_rd && span_hit[0];
        cmd.dt_deassert = qual && !bus_rd && span_hit[1];
        cmd.route_int   = qual && !bus_rd && (a32 == RT_INT_A);
        cmd.route_ext   = qual && !bus_rd && (a32 == RT_EXT_A);
        cmd.ctlr_pulse  = qual && !bus_rd && (a32 == CRST_A);
    end

endmodule

// File: rtl/dsk_ctl_latches.sv
// Control state registers.
// Holds head select, drive-type select, the routing bit and the
// one-clock controller reset pulse. Assumes at most one strobe per cycle.
// Reset is synchronous and active low.
module dsk_ctl_latches
    import dsk_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dsk_cmd_t cmd,
    output logic     head_sel,
    output logic     dtype_sel_n,
    output logic     route_int,
    output logic     ctlr_rst
);
    // Head select: cleared by the low span, set by the high span (reads).
    always_ff @(posedge clk) begin
        if (!rst_n)           head_sel <= 1'b0;
        else if (cmd.hd_clr)  head_sel <= 1'b0;
        else if (cmd.hd_set)  head_sel <= 1'b1;
    end

    // Drive-type select, active low: low span asserts, high span releases (writes).
    always_ff @(posedge clk) begin
        if (!rst_n)                dtype_sel_n <= 1'b1;
        else if (cmd.dt_assert)    dtype_sel_n <= 1'b0;
        else if (cmd.dt_deassert)  dtype_sel_n <= 1'b1;
    end

    // Routing bit: 1 steers the drive-2 enable to the internal drive.
    always_ff @(posedge clk) begin
        if (!rst_n)              route_int <= 1'b0;
        else if (cmd.route_int)  route_int <= 1'b1;
        else if (cmd.route_ext)  route_int <= 1'b0;
    end

    // Controller reset: high for the clock after each qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ctlr_rst <= 1'b0;
        else        ctlr_rst <= cmd.ctlr_pulse;
    end

endmodule

// File: rtl/dsk_ctl_route.sv
// Drive-2 enable steering.
// Passes the active-low enable to the selected output without delay and
// holds the other output at its inactive high level.
module dsk_ctl_route (
    input  logic route_int,
    input  logic drv2_en_n,
    output logic ext_en_n,
    output logic int_en_n
);
    // Select which pin carries the enable.
    always_comb begin
        ext_en_n = route_int ? 1'b1 : drv2_en_n;
        int_en_n = route_int ? drv2_en_n : 1'b1;
    end

endmodule

// File: rtl/dsk_ctl_router.sv
// Top of the disk control latch and select router.
// Wires the decoder, the state registers and the enable steering.
// Assumes bus inputs are synchronous to clk.
module dsk_ctl_router
    import dsk_ctl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [31:0] WIN_BASE  = 32'h0000_C800,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_0800,
    parameter logic [31:0] SPAN_LO   = 32'h0000_CE40,
    parameter logic [31:0] SPAN_HI   = 32'h0000_CE60,
    parameter logic [31:0] SPAN_LEN  = 32'h0000_0020,
    parameter logic [31:0] RT_INT_A  = 32'h0000_CC80,
    parameter logic [31:0] RT_EXT_A  = 32'h0000_CCC0,
    parameter logic [31:0] CRST_A    = 32'h0000_CC40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_phi,
    input  logic              win_sel_n,
    input  logic              drv2_en_n,
    output logic              head_sel,
    output logic              dtype_sel_n,
    output logic              ctlr_rst,
    output logic              ext_en_n,
    output logic              int_en_n
);
    dsk_cmd_t cmd;
    logic     route_int;

    dsk_ctl_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
        .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI), .SPAN_LEN(SPAN_LEN),
        .RT_INT_A(RT_INT_A), .RT_EXT_A(RT_EXT_A), .CRST_A(CRST_A)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_phi  (bus_phi),
        .win_sel_n(win_sel_n),
        .cmd      (cmd)
    );

    dsk_ctl_latches u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .head_sel   (head_sel),
        .dtype_sel_n(dtype_sel_n),
        .route_int  (route_int),
        .ctlr_rst   (ctlr_rst)
    );

    dsk_ctl_route u_rt (
        .route_int(route_int),
        .drv2_en_n(drv2_en_n),
        .ext_en_n (ext_en_n),
        .int_en_n (int_en_n)
    );

endmodule

// File: rtl/dsk_ctl_router_chk.sv
// Port-level property checker for dsk_ctl_router, bound to every instance.
// Decodes the bus on its own from the parameters and relates it to the outputs.
module dsk_ctl_router_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [31:0] WIN_BASE  = 32'h0000_C800,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_0800,
    parameter logic [31:0] SPAN_LO   = 32'h0000_CE40,
    parameter logic [31:0] SPAN_HI   = 32'h0000_CE60,
    parameter logic [31:0] SPAN_LEN  = 32'h0000_0020,
    parameter logic [31:0] RT_INT_A  = 32'h0000_CC80,
    parameter logic [31:0] RT_EXT_A  = 32'h0000_CCC0,
    parameter logic [31:0] CRST_A    = 32'h0000_CC40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_phi,
    input logic              win_sel_n,
    input logic              drv2_en_n,
    input logic              head_sel,
    input logic              dtype_sel_n,
    input logic              ctlr_rst,
    input logic              ext_en_n,
    input logic              int_en_n
);
    logic [31:0] a;
    logic        q, lo_hit, hi_hit;

    assign a      = 32'(bus_addr);
    assign q      = !win_sel_n && bus_phi && (a >= WIN_BASE) && (a < WIN_BASE + WIN_SIZE);
    assign lo_hit = (a >= SPAN_LO) && (a < SPAN_LO + SPAN_LEN);
    assign hi_hit = (a >= SPAN_HI) && (a < SPAN_HI + SPAN_LEN);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!head_sel && dtype_sel_n && !ctlr_rst && int_en_n));

    a_r2_head_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q && bus_rd && lo_hit) |=> !head_sel);

    a_r3_head_set: assert property (@(posedge clk) disable iff (!rst_n)
        (q && bus_rd && hi_hit) |=> head_sel);

    a_r4_dtype_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !bus_rd && lo_hit) |=> !dtype_sel_n);

    a_r5_dtype_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !bus_rd && hi_hit) |=> dtype_sel_n);

    a_r6_route_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !bus_rd && a == RT_INT_A) |=> ext_en_n);

    a_r7_route_external: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !bus_rd && a == RT_EXT_A) |=> int_en_n);

    a_r8_one_side_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en_n || int_en_n));

    a_r9_pulse_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !bus_rd && a == CRST_A) |=> ctlr_rst);

    a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ctlr_rst |-> $past(q && !bus_rd && a == CRST_A));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q |=> ($stable(head_sel) && $stable(dtype_sel_n) && !ctlr_rst));

endmodule

bind dsk_ctl_router dsk_ctl_router_chk #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI), .SPAN_LEN(SPAN_LEN),
    .RT_INT_A(RT_INT_A), .RT_EXT_A(RT_EXT_A), .CRST_A(CRST_A)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_phi(bus_phi), .win_sel_n(win_sel_n), .drv2_en_n(drv2_en_n),
    .head_sel(head_sel), .dtype_sel_n(dtype_sel_n), .ctlr_rst(ctlr_rst),
    .ext_en_n(ext_en_n), .int_en_n(int_en_n)
);

// File: tb/dsk_ctl_router_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is stepped on every clock and
// compared with all outputs at the following falling edge.
module dsk_ctl_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b1;
    logic        bus_phi = 1'b0;
    logic        win_sel_n = 1'b1;
    logic        drv2_en_n = 1'b1;
    logic        head_sel, dtype_sel_n, ctlr_rst, ext_en_n, int_en_n;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    bit m_hd = 0, m_dt_n = 1, m_int = 0, m_pulse = 0;

    always #4 clk = ~clk;   // 125 MHz

    dsk_ctl_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_phi(bus_phi), .win_sel_n(win_sel_n), .drv2_en_n(drv2_en_n),
        .head_sel(head_sel), .dtype_sel_n(dtype_sel_n), .ctlr_rst(ctlr_rst),
        .ext_en_n(ext_en_n), .int_en_n(int_en_n)
    );

    // Model step from the stated requirements.
    task automatic model_step();
        int  a   = int'(bus_addr);
        bit  q   = !win_sel_n && bus_phi && a >= 'hC800 && a < 'hD000;
        if (!rst_n) begin
            m_hd = 0; m_dt_n = 1; m_int = 0; m_pulse = 0;
            return;
        end
        m_pulse = 0;
        if (!q) return;
        if (bus_rd) begin
            if (a >= 'hCE40 && a <= 'hCE5F) m_hd = 0;
            if (a >= 'hCE60 && a <= 'hCE7F) m_hd = 1;
        end else begin
            if (a >= 'hCE40 && a <= 'hCE5F) m_dt_n = 0;
            if (a >= 'hCE60 && a <= 'hCE7F) m_dt_n = 1;
            if (a == 'hCC80) m_int = 1;
            if (a == 'hCCC0) m_int = 0;
            if (a == 'hCC40) m_pulse = 1;
        end
    endtask

    task automatic compare();
        logic [4:0] exp_v, act_v;
        exp_v = {m_hd, m_dt_n, m_pulse, (m_int ? 1'b1 : drv2_en_n), (m_int ? drv2_en_n : 1'b1)};
        act_v = {head_sel, dtype_sel_n, ctlr_rst, ext_en_n, int_en_n};
        vectors++;
        if (act_v !== exp_v) begin
            miscompares++;
            $display("FAIL %s at %0t: {hd,dt_n,crst,ext_n,int_n} actual=%b expected=%b",
                     cur_req, $time, act_v, exp_v);
        end
    endtask

    // One bus clock: drive at falling edge, step model at rising edge, compare after.
    task automatic cyc(input bit rd, input logic [15:0] a, input bit sel_n,
                       input bit phi, input bit d2);
        bus_rd = rd; bus_addr = a; win_sel_n = sel_n; bus_phi = phi; drv2_en_n = d2;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic rd_q(input logic [15:0] a);  cyc(1, a, 0, 1, 1); endtask
    task automatic wr_q(input logic [15:0] a);  cyc(0, a, 0, 1, 1); endtask
    task automatic idle(input bit d2);          cyc(1, 16'h0000, 1, 0, d2); endtask

    initial begin
        @(negedge clk);
        // R1: activity during reset is ignored, outputs at reset values
        cur_req = "R1";
        rst_n = 0;
        wr_q(16'hCC80); rd_q(16'hCE60); wr_q(16'hCE40); wr_q(16'hCC40);
        rst_n = 1;
        idle(0); idle(1);

        // R3 then R2: head select by reads at span edges
        cur_req = "R3"; rd_q(16'hCE60); idle(1); rd_q(16'hCE7F); idle(1);
        cur_req = "R2"; rd_q(16'hCE5F); idle(1); rd_q(16'hCE60); rd_q(16'hCE40); idle(1);

        // R4 / R5: drive-type select by writes
        cur_req = "R4"; wr_q(16'hCE45); idle(1); wr_q(16'hCE5F); idle(1);
        cur_req = "R5"; wr_q(16'hCE7F); idle(1); wr_q(16'hCE40); wr_q(16'hCE60); idle(1);

        // R6 + R8: internal routing, drv2 enable toggled
        cur_req = "R6"; wr_q(16'hCC80);
        cur_req = "R8"; idle(0); idle(1); idle(0);
        // R7 + R8: back to external
        cur_req = "R7"; wr_q(16'hCCC0);
        cur_req = "R8"; idle(0); idle(1); idle(0);

        // R9: single and stretched controller reset pulse
        cur_req = "R9"; wr_q(16'hCC40); idle(1); idle(1);
        wr_q(16'hCC40); wr_q(16'hCC40); idle(1);

        // R10: unqualified cycles touch nothing
        cur_req = "R10";
        cyc(1, 16'hCE60, 1, 1, 1); cyc(0, 16'hCE40, 0, 0, 1);
        cyc(0, 16'hCC80, 1, 1, 0); cyc(0, 16'hCC40, 0, 0, 1); idle(0);

        // R11: undecoded locations and wrong direction do nothing
        cur_req = "R11";
        rd_q(16'hCE80); rd_q(16'hDE60); wr_q(16'hDE40); wr_q(16'hCE3F);
        wr_q(16'hCE80); rd_q(16'hCC80); cyc(1, 16'hCC80, 0, 1, 0);
        rd_q(16'hCC40); wr_q(16'hCC81); cyc(0, 16'hC880, 0, 1, 0);
        wr_q(16'h4C80); idle(0);

        // R1: reset from a non-default state
        cur_req = "R1";
        wr_q(16'hCC80); rd_q(16'hCE70); wr_q(16'hCE50); idle(0);
        rst_n = 0; idle(0);
        rst_n = 1; idle(0); idle(1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule